// File: doc/BRIEF.md
# Pipelined unsigned array multiplier

This block multiplies two unsigned W-bit operands (W = 4 by default) and returns the 2W-bit product. It is a ripple-carry array in which every full adder is followed by a register. One adder row handles each multiplier bit. Within a row, the carry advances by one column per clock. A row's output bits feed the next row one column lower.

Each partial-product bit (op_a[c] AND op_b[r]) passes through its own delay line. The delay is matched to the clock on which its adder fires, so an operand pair that is sampled on one edge meets the correct carries and sums further down the array. Product bits that finish early are held in deskew delay lines, so all 2W bits of a product leave on the same cycle. A valid flag travels through a delay line of the same length.

A new pair may be applied on every clock. The result of each pair appears 3W-2 clocks later. The reset input clears all state asynchronously, and its release is synchronised inside the block.

Top module: `systolic_mult`

## Requirements
- R1: For every accepted pair, `product` equals op_a × op_b as unsigned values. This holds at the extremes 0×0, 15×15 = 225, 1×15 and 15×1.
- R2: The latency is 3W-2 = 10 rising edges, counting the edge that samples the pair. The result is on the outputs right after the tenth edge.
- R3: Pairs applied on consecutive clocks each yield their own product on consecutive output cycles. No bits are mixed between neighbouring pairs.
- R4: `out_valid` is high on exactly the output cycles that belong to pairs sampled with `in_valid` = 1. Gaps in `in_valid` are reproduced unchanged.
- R5: `product` reads 0 whenever `out_valid` is 0.
- R6: While `rst_n` is low, `out_valid` and `product` are 0, without waiting for a clock edge. Pairs in flight when reset is asserted never appear afterwards.
- R7: After `rst_n` rises, the first two rising edges are still treated as reset, and inputs presented to them are ignored. The third edge is the first one that accepts a pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released through a two-stage synchroniser |
| in_valid | input | 1 | Marks the current operand pair as real |
| op_a | input | W | Multiplicand, unsigned |
| op_b | input | W | Multiplier, unsigned |
| out_valid | output | 1 | Marks a product on `product` |
| product | output | 2W | Unsigned product, zero when `out_valid` is low |

## Verification
The hardest case to reach from the ports is a full pipeline of distinct pairs in which long carry ripples overlap in time. In that case a single misaligned delay line corrupts a neighbour's product rather than the pair's own. The bench drives dense back-to-back random pairs with occasional gaps, and adds directed all-ones and single-bit operands. It also asserts reset while products are in flight and drives valid pairs into the two synchroniser cycles after release. In each case the dropped and ignored pairs must never surface at the outputs.

// File: rtl/smul_pkg.sv
package smul_pkg;

  // Clock edges from sampling a pair to presenting its product.
  function automatic int latency(input int w);
    return 3 * w - 2;
  endfunction

  // Delay lines in front of the adder at row r, column c.
  function automatic int pp_delay(input int r, input int c);
    return 2 * r + c;
  endfunction

endpackage

// File: rtl/smul_dly.sv
// Shift-register delay of DEPTH (>= 1) clocks on a WIDTH-bit bus.
module smul_dly #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [DEPTH];
  logic [WIDTH-1:0] stg_d [DEPTH];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < DEPTH; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[DEPTH-1];

endmodule

// File: rtl/smul_fa_cell.sv
// Registered full adder whose partial-product input is first skewed
// by PP_DLY clocks.
module smul_fa_cell #(
  parameter int PP_DLY = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pp,
  input  logic x,
  input  logic cin,
  output logic sum_q,
  output logic cout_q
);

  logic pp_al;
  logic sum_d;
  logic cout_d;

  generate
    if (PP_DLY == 0) begin : g_nodly
      assign pp_al = pp;
    end else begin : g_dly
      smul_dly #(.WIDTH(1), .DEPTH(PP_DLY)) u_pp_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pp),
        .q     (pp_al)
      );
    end
  endgenerate

  always_comb begin
    sum_d  = pp_al ^ x ^ cin;
    cout_d = (pp_al & x) | (cin & (pp_al ^ x));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= 1'b0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      cout_q <= cout_d;
    end
  end

endmodule

// File: rtl/smul_rst_sync.sv
// Asynchronous assertion, two-flop synchronous release.
module smul_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_o = hold_q;

endmodule

// File: rtl/systolic_mult.sv
module systolic_mult #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           out_valid,
  output logic [2*W-1:0] product
);

  localparam int LAT  = smul_pkg::latency(W);
  localparam int PW   = 2 * W;
  localparam int LAST = W - 1;

  logic           rst_s;
  logic           s_q [W][W];
  logic           c_q [W][W];
  logic [PW-1:0]  prod_al;
  logic           vld_al;

  smul_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_s)
  );

  // Adder array: row r adds (op_a & op_b[r]) to the previous row shifted down.
  generate
    for (genvar r = 0; r < W; r++) begin : g_row
      for (genvar c = 0; c < W; c++) begin : g_col
        logic x_in;
        logic cin_in;

        if (r == 0) begin : g_x0
          assign x_in = 1'b0;
        end else if (c < W - 1) begin : g_xs
          assign x_in = s_q[r-1][c+1];
        end else begin : g_xc
          smul_dly #(.WIDTH(1), .DEPTH(1)) u_cdly (
            .clk   (clk),
            .rst_n (rst_s),
            .d     (c_q[r-1][W-1]),
            .q     (x_in)
          );
        end

        if (c == 0) begin : g_c0
          assign cin_in = 1'b0;
        end else begin : g_cr
          assign cin_in = c_q[r][c-1];
        end

        smul_fa_cell #(.PP_DLY(smul_pkg::pp_delay(r, c))) u_fa (
          .clk    (clk),
          .rst_n  (rst_s),
          .pp     (op_a[c] & op_b[r]),
          .x      (x_in),
          .cin    (cin_in),
          .sum_q  (s_q[r][c]),
          .cout_q (c_q[r][c])
        );
      end
    end
  endgenerate

  // Deskew: low product bits leave column 0 of early rows.
  generate
    for (genvar r = 0; r < LAST; r++) begin : g_lo
      smul_dly #(.WIDTH(1), .DEPTH(LAT - 2 * r - 1)) u_lo_dly (
        .clk   (clk),
        .rst_n (rst_s),
        .d     (s_q[r][0]),
        .q     (prod_al[r])
      );
    end
    for (genvar c = 0; c < W; c++) begin : g_hi
      if (c == W - 1) begin : g_hi_direct
        assign prod_al[LAST+c] = s_q[LAST][c];
      end else begin : g_hi_dly
        smul_dly #(.WIDTH(1), .DEPTH(W - 1 - c)) u_hi_dly (
          .clk   (clk),
          .rst_n (rst_s),
          .d     (s_q[LAST][c]),
          .q     (prod_al[LAST+c])
        );
      end
    end
  endgenerate

  assign prod_al[PW-1] = c_q[LAST][W-1];

  smul_dly #(.WIDTH(1), .DEPTH(LAT)) u_vld (
    .clk   (clk),
    .rst_n (rst_s),
    .d     (in_valid),
    .q     (vld_al)
  );

  assign out_valid = vld_al;
  assign product   = vld_al ? prod_al : '0;

endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic           out_valid,
  input logic [2*W-1:0] product
);

  localparam int LAT  = smul_pkg::latency(W);
  localparam int PW   = 2 * W;
  localparam int CMAX = LAT + 2;
  localparam int CW   = $clog2(CMAX + 1);

  logic [CW-1:0] since_q;
  logic          acc;
  logic          vp_q [LAT];
  logic [PW-1:0] pp_q [LAT];

  assign acc = in_valid && (since_q >= CW'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      for (int i = 0; i < LAT; i++) begin
        vp_q[i] <= 1'b0;
        pp_q[i] <= '0;
      end
    end else begin
      if (since_q < CW'(CMAX)) since_q <= since_q + CW'(1);
      vp_q[0] <= acc;
      pp_q[0] <= {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};
      for (int i = 1; i < LAT; i++) begin
        vp_q[i] <= vp_q[i-1];
        pp_q[i] <= pp_q[i-1];
      end
    end
  end

  p_valid_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vp_q[LAT-1]);

  p_product_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> product == pp_q[LAT-1]);

  p_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> product == '0);

  p_no_early_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q < CW'(CMAX)) |-> !out_valid);

endmodule

bind systolic_mult smul_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .out_valid (out_valid),
  .product   (product)
);

// File: tb/sim_systolic_mult.sv
`timescale 1ns/1ps
module sim_systolic_mult;

  localparam int W   = 4;
  localparam int LAT = 3 * W - 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [W-1:0]   op_a = '0;
  logic [W-1:0]   op_b = '0;
  logic           out_valid;
  logic [2*W-1:0] product;

  int unsigned edge_n = 0;
  int          since_rel = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  string       cur_req = "R6";
  bit          exp_v [64];
  logic [7:0]  exp_p [64];

  systolic_mult #(.W(W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .product   (product)
  );

  always #2 clk = ~clk;

  always @(posedge clk) edge_n <= edge_n + 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rel <= 0;
    else if (since_rel < 100) since_rel <= since_rel + 1;
  end

  function automatic logic [7:0] ref_mul(input logic [3:0] a, input logic [3:0] b);
    return {4'b0, a} * {4'b0, b};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, edge_n, act, exp);
    end
  endtask

  task automatic check_out();
    int  idx;
    bit  ev;
    idx = int'(edge_n % 64);
    ev  = exp_v[idx];
    chk(cur_req, {7'b0, out_valid}, {7'b0, ev});
    chk(cur_req, product, ev ? exp_p[idx] : 8'd0);
    exp_v[idx] = 1'b0;
  endtask

  task automatic drive(input bit v, input logic [3:0] a, input logic [3:0] b);
    int idx;
    in_valid = v; op_a = a; op_b = b;
    if (v && rst_n && since_rel >= 2) begin
      idx = int'((edge_n + LAT) % 64);
      exp_v[idx] = 1'b1;
      exp_p[idx] = ref_mul(a, b);
    end
  endtask

  task automatic cyc(input bit v, input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    check_out();
    drive(v, a, b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 4'd0);
  endtask

  initial begin
    #(4 * 50000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin exp_v[i] = 1'b0; exp_p[i] = '0; end

    // R6: outputs held at zero in reset
    cur_req = "R6";
    idle(5);

    // R7: release with valid pairs on the first three edges
    cur_req = "R7";
    @(negedge clk);
    check_out();
    rst_n = 1'b1;
    drive(1'b1, 4'd15, 4'd15);
    cyc(1'b1, 4'd15, 4'd14);
    cyc(1'b1, 4'd13, 4'd11);
    idle(LAT + 4);

    // R2: isolated pulses, exact latency
    cur_req = "R2";
    cyc(1'b1, 4'd7, 4'd9);
    idle(LAT + 2);
    cyc(1'b1, 4'd15, 4'd15);
    idle(LAT + 2);

    // R1: corner operands back to back
    cur_req = "R1";
    cyc(1'b1, 4'd0,  4'd0);
    cyc(1'b1, 4'd15, 4'd15);
    cyc(1'b1, 4'd1,  4'd15);
    cyc(1'b1, 4'd15, 4'd1);
    cyc(1'b1, 4'd0,  4'd15);
    cyc(1'b1, 4'd8,  4'd8);
    cyc(1'b1, 4'd15, 4'd0);
    idle(LAT + 2);

    // R3: dense random pairs, no gaps
    cur_req = "R3";
    for (int i = 0; i < 200; i++) cyc(1'b1, 4'($urandom), 4'($urandom));
    idle(LAT + 2);

    // R4 / R5: random gaps in in_valid, operands still toggling
    cur_req = "R4";
    for (int i = 0; i < 300; i++) cyc(($urandom % 4) != 0, 4'($urandom), 4'($urandom));
    cur_req = "R5";
    for (int i = 0; i < 60; i++) cyc(($urandom % 3) == 0, 4'($urandom), 4'($urandom));
    idle(LAT + 2);

    // R6: reset asserted with products in flight
    cur_req = "R6";
    for (int i = 0; i < 6; i++) cyc(1'b1, 4'($urandom), 4'($urandom));
    @(negedge clk);
    check_out();
    rst_n = 1'b0;
    drive(1'b0, 4'd0, 4'd0);
    for (int i = 0; i < 64; i++) exp_v[i] = 1'b0;
    #1;
    chk("R6", {7'b0, out_valid}, 8'd0);
    chk("R6", product, 8'd0);
    idle(3);
    @(negedge clk);
    check_out();
    rst_n = 1'b1;
    drive(1'b0, 4'd0, 4'd0);
    idle(LAT + 6);

    // R1: final sweep of all-ones against single bits
    cur_req = "R1";
    for (int i = 0; i < 4; i++) cyc(1'b1, 4'd15, 4'(1 << i));
    for (int i = 0; i < 4; i++) cyc(1'b1, 4'(1 << i), 4'd15);
    idle(LAT + 2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule